// File: doc/BRIEF.md
# Code block classifier and slot mask

The block examines one aligned 256-bit program code block per cycle. It sorts the block into one of three kinds, using leading bit patterns that no instruction is allowed to start with. The kinds are a header block, an independent non-header block and a dependent non-header block.

For a header block, the block takes the ignored-slot count supplied by the header parser. That count gives the number of 32-bit slots, counted back from the high-address end, that hold no instructions. The block also takes a flag that says whether the header itself fills one slot or two. From these it builds an eight-bit mask of the slots that the decoder must treat as instructions. A count beyond the legal range for the header size is reported as an error.

For an independent block, it marks which 32-bit slots carry a pair of 16-bit instructions. Results are registered and appear one cycle after the block is accepted.

Top module: `blk_sorter`

## Requirements
- R1: Bit ordering. The first bit of the block is `in_block[255]`, which is the most significant bit of the lowest-address byte. Slot i occupies `in_block[255-32*i -: 32]`, and its first bit is `in_block[255-32*i]`. A block whose first four bits are 0011 or 0100 is classified as a header, with `out_kind` = 2'b10.
- R2: A block whose first seven bits are 0111111 or 1111111 is classified as a header (2'b10). This holds even though its first bit may be 1.
- R3: A block whose first bit is 1 and that matches no header pattern is classified as independent, with `out_kind` = 2'b01.
- R4: A block whose first bit is 0 and that matches no header pattern is classified as dependent, with `out_kind` = 2'b00. The value 2'b11 never appears.
- R5: For a valid header, `out_slot_mask` bit i is 1 exactly when two conditions hold:
  - i is at least the header size in slots (1 when `in_wide_hdr` = 0, 2 when it is 1);
  - i is less than 8 minus `in_skip`.
- R6: For a header, `out_skip_err` is 1 when `in_skip` exceeds 6 with a one-slot header, or exceeds 5 with a two-slot header. Whenever the error is set, `out_slot_mask` is all zero.
- R7: For an independent block, `out_pair_mask` bit i (i = 1..7) is 1 exactly when the first bit of slot i is 0. Bit 0 is always 0.
- R8: For a non-header block, `out_slot_mask` is zero and `out_skip_err` is 0. For any block that is not independent, `out_pair_mask` is zero.
- R9: Results and `out_valid` appear on the clock edge that samples `in_valid` high. `out_valid` is high for exactly those cycles. While `in_valid` is low, the result outputs keep their last values.
- R10: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block is offered this cycle |
| in_block | input | 256 | Code block; bit 255 is the first bit of the block |
| in_wide_hdr | input | 1 | 1: the header fills two slots, 0: one slot |
| in_skip | input | 3 | Count of trailing slots not decoded |
| out_valid | output | 1 | Results below belong to the block just accepted |
| out_kind | output | 2 | 00 dependent, 01 independent, 10 header |
| out_slot_mask | output | 8 | Bit i set: slot i is decoded as an instruction |
| out_pair_mask | output | 8 | Bit i set: slot i holds two 16-bit instructions |
| out_skip_err | output | 1 | Ignored-slot count out of range for the header size |

## Verification
Each result is due one cycle after its block is offered. The bench drives a block at a falling edge, and the rising edge that follows registers the outputs. It compares the outputs at the next falling edge, well clear of any edge. It then holds `in_valid` low for one cycle and samples again at the following falling edge. That second sample confirms that `out_valid` has dropped and that the results held their values. The sweep covers every seven-bit prefix, both header sizes and all eight counts, with random slot leading bits.

// File: rtl/blk_sorter.sv
`timescale 1ns/1ps
module blk_sorter #(
  parameter int SLOTS  = 8,
  parameter int SLOT_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  input  logic [SLOTS*SLOT_W-1:0]   in_block,
  input  logic                      in_wide_hdr,
  input  logic [2:0]                in_skip,
  output logic                      out_valid,
  output logic [1:0]                out_kind,
  output logic [SLOTS-1:0]          out_slot_mask,
  output logic [SLOTS-1:0]          out_pair_mask,
  output logic                      out_skip_err
);
  localparam int TOP = SLOTS*SLOT_W - 1;
  localparam logic [1:0] K_DEP = 2'b00, K_IND = 2'b01, K_HDR = 2'b10;

  logic [6:0]       lead;
  logic             is_hdr, err_d;
  logic [1:0]       kind_d;
  logic [SLOTS-1:0] slot_d, pair_d;

  assign lead   = in_block[TOP -: 7];
  assign is_hdr = (lead[6:3] == 4'b0011) || (lead[6:3] == 4'b0100) || (lead[5:0] == 6'b111111);
  assign kind_d = is_hdr ? K_HDR : (lead[6] ? K_IND : K_DEP);
  assign err_d  = is_hdr && (in_skip > (in_wide_hdr ? 3'd5 : 3'd6));

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      slot_d[i] = is_hdr && !err_d && (i >= (in_wide_hdr ? 2 : 1)) && (i < SLOTS - int'(in_skip));
      pair_d[i] = (kind_d == K_IND) && (i != 0) && !in_block[TOP - SLOT_W*i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_kind      <= K_DEP;
      out_slot_mask <= '0;
      out_pair_mask <= '0;
      out_skip_err  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_kind      <= kind_d;
        out_slot_mask <= slot_d;
        out_pair_mask <= pair_d;
        out_skip_err  <= err_d;
      end
    end
  end

  assert_kind_legal_R4: assert property (@(posedge clk) disable iff (!rst_n) out_kind != 2'b11);
  assert_err_clears_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_skip_err |-> (out_slot_mask == '0));
  assert_nonhdr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind != K_HDR) |-> (!out_skip_err && out_slot_mask == '0));
  assert_pair_only_ind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_kind != K_IND) |-> (out_pair_mask == '0));
  assert_hdr_slot0_R5: assert property (@(posedge clk) disable iff (!rst_n) !out_slot_mask[0] && !out_pair_mask[0]);
  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_kind) && $stable(out_slot_mask) && $stable(out_pair_mask)));
endmodule

// File: tb/tb_blk_sorter.sv
`timescale 1ns/1ps
module tb_blk_sorter;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [255:0] in_block = '0;
  logic         in_wide_hdr = 1'b0;
  logic [2:0]   in_skip = '0;
  logic         out_valid, out_skip_err;
  logic [1:0]   out_kind;
  logic [7:0]   out_slot_mask, out_pair_mask;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  blk_sorter dut (.clk, .rst_n, .in_valid, .in_block, .in_wide_hdr, .in_skip,
                  .out_valid, .out_kind, .out_slot_mask, .out_pair_mask, .out_skip_err);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] ek;
    logic [7:0] es, ep;
    logic       ee;
    int         hs;
    repeat (3) @(negedge clk);
    chk("R10 valid", {7'd0, out_valid}, 8'd0);
    chk("R10 kind", {6'd0, out_kind}, 8'd0);
    chk("R10 slot", out_slot_mask, 8'd0);
    chk("R10 pair", out_pair_mask, 8'd0);
    chk("R10 err", {7'd0, out_skip_err}, 8'd0);
    rst_n = 1'b1;
    for (int p = 0; p < 128; p++) begin
      for (int w = 0; w < 2; w++) begin
        for (int s = 0; s < 8; s++) begin
          @(negedge clk);
          for (int k = 0; k < 8; k++) in_block[255-32*k -: 32] = $urandom;
          in_block[255 -: 7] = 7'(p);
          in_wide_hdr = w[0];
          in_skip = 3'(s);
          in_valid = 1'b1;
          if (p[6:3] == 4'b0011 || p[6:3] == 4'b0100 || p[5:0] == 6'h3f) ek = 2'b10;
          else if (p[6]) ek = 2'b01;
          else ek = 2'b00;
          hs = w + 1;
          ee = (ek == 2'b10) && (s > 6 - w);
          es = '0; ep = '0;
          for (int k = 0; k < 8; k++) begin
            if (ek == 2'b10 && !ee && k >= hs && k < 8 - s) es[k] = 1'b1;
            if (ek == 2'b01 && k > 0 && !in_block[255-32*k]) ep[k] = 1'b1;
          end
          @(negedge clk);
          in_valid = 1'b0;
          chk("R9 valid", {7'd0, out_valid}, 8'd1);
          if (ek == 2'b10 && p[6:3] != 4'b0011 && p[6:3] != 4'b0100) chk("R2 kind", {6'd0, out_kind}, {6'd0, ek});
          else if (ek == 2'b10) chk("R1 kind", {6'd0, out_kind}, {6'd0, ek});
          else if (ek == 2'b01) chk("R3 kind", {6'd0, out_kind}, {6'd0, ek});
          else chk("R4 kind", {6'd0, out_kind}, {6'd0, ek});
          if (ek == 2'b10) begin
            chk("R5/R6 slot mask", out_slot_mask, es);
            chk("R6 err", {7'd0, out_skip_err}, {7'd0, ee});
          end else begin
            chk("R8 slot mask", out_slot_mask, 8'd0);
            chk("R8 err", {7'd0, out_skip_err}, 8'd0);
          end
          if (ek == 2'b01) chk("R7 pair mask", out_pair_mask, ep);
          else chk("R8 pair mask", out_pair_mask, 8'd0);
          in_block = ~in_block;
          @(negedge clk);
          chk("R9 idle valid", {7'd0, out_valid}, 8'd0);
          chk("R9 hold kind", {6'd0, out_kind}, {6'd0, ek});
          chk("R9 hold slot", out_slot_mask, es);
        end
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule